// File: doc/BRIEF.md
# Programmable Galois CRC and Pseudo-Random Engine

This engine keeps a software-programmable 32-bit feedback polynomial and a 32-bit Galois shift register. The same register serves three jobs. As a CRC unit it absorbs one byte per clock from one of two byte streams and leaves the running checksum in the state register. As a pseudo-random source it steps the register eight times per clock and emits a byte each clock. As an entropy path it either mixes a single entropy bit into the feedback of one step per clock, or it forwards that bit untouched so the raw source can be characterised.

A bit-order control selects least-significant-first or most-significant-first processing. The same control sets the orientation in which the polynomial and state registers are seen at the register ports: in most-significant-first mode both read and write in normal (non-reflected) form. The state register is seeded or preset by writing it while the engine is idle.

Control word layout (write and read): bit 0 CRC enable, bit 1 MSB-first order, bit 2 PRNG enable, bit 3 entropy enable, bit 4 CRC source select (0 = input-side stream, 1 = output-side stream).

Top module: `gf_engine`

## Requirements
- R1: After reset the polynomial, state and control read as 0, both stream ready outputs are 0 and rndValid is 0.
- R2: A polynomial or state value written in the current bit order reads back unchanged; toggling the order bit (control bit 1) shows both registers bit-reversed.
- R3: With control bit 0 set and bit 1 clear, each accepted byte updates the state as a reflected CRC (data bit 0 first, shift right, XOR polynomial when state bit 0 XOR data bit is 1), one byte per clock.
- R4: With control bits 0 and 1 set, each accepted byte updates the state as a normal CRC (data bit 7 first, shift left, XOR polynomial when state bit 31 XOR data bit is 1), one byte per clock.
- R5: Control bit 4 picks the CRC stream: 0 raises inSideReady only, 1 raises outSideReady only; bytes on the unselected stream are ignored.
- R6: A control write that sets the PRNG enable (bit 2) leaves the CRC enable (bit 0) reading 0, and no stream is ready.
- R7: With PRNG on and entropy off, every clock the state takes eight zero-data steps and rndValid=1, rndWide=1; the feedback bit of step i lands in rndData bit i (LSB-first) or bit 7-i (MSB-first).
- R8: With PRNG and entropy on, every clock the state takes one step whose feedback bit is XORed with entropyIn; rndWide=0 and rndData holds that feedback bit in bit 0 with bits 7..1 zero.
- R9: With PRNG off and entropy on, rndData bit 0 equals the entropyIn of the previous clock, rndWide=0, and the state does not change.
- R10: A state write that arrives in a clock where the PRNG is enabled or a CRC byte is accepted is ignored.
- R11: With PRNG and entropy both off, rndValid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| polyWrEn | input | 1 | Polynomial write strobe |
| polyWrData | input | 32 | Polynomial write value |
| polyRdData | output | 32 | Polynomial in current bit order |
| stateWrEn | input | 1 | State write strobe (seed / CRC preset) |
| stateWrData | input | 32 | State write value |
| stateRdData | output | 32 | State in current bit order |
| ctrlWrEn | input | 1 | Control write strobe |
| ctrlWrData | input | 5 | Control write value |
| ctrlRdData | output | 5 | Effective control value |
| inSideValid | input | 1 | Input-side byte valid |
| inSideData | input | 8 | Input-side byte |
| inSideReady | output | 1 | Input-side byte accepted when valid |
| outSideValid | input | 1 | Output-side byte valid |
| outSideData | input | 8 | Output-side byte |
| outSideReady | output | 1 | Output-side byte accepted when valid |
| entropyIn | input | 1 | Entropy source bit |
| rndValid | output | 1 | Random output valid |
| rndWide | output | 1 | 1 = full byte, 0 = single bit in bit 0 |
| rndData | output | 8 | Random output |

## Verification
The bench runs the standard reflected and normal 32-bit CRCs over a nine-byte ASCII string and compares against both its own bit-serial model and the published check values, so a design with the wrong shift direction, data-bit order or unreflected register port would give a different checksum. It switches the order bit and expects reversed readback, catching a design that stores registers literally. It drives junk on the unselected stream and injects state writes during absorption and PRNG runs; a design that lets them through corrupts the final state. It requests CRC and PRNG together and varies the entropy pattern across mixed and raw modes, where a missing exclusion, a wrong output packing or a state that moves in raw mode shows up as a scoreboard mismatch.

// File: rtl/gf_pkg.sv
package gf_pkg;

  // Control word, bit 0 is crcEn
  typedef struct packed {
    logic srcSel;
    logic entEn;
    logic prngEn;
    logic msbFirst;
    logic crcEn;
  } gfCtrl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic absorb;
    logic prngByte;
    logic mixBit;
    logic rawBit;
    logic loadState;
    logic msbFirst;
  } gfStrobes_t;

endpackage

// File: rtl/gf_ctrl.sv
module gf_ctrl
  import gf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlWrEn,
  input  gfCtrl_t           ctrlWrData,
  input  logic              stateWrEn,
  input  logic              inSideValid,
  input  logic [BYTE_W-1:0] inSideData,
  input  logic              outSideValid,
  input  logic [BYTE_W-1:0] outSideData,
  output logic              inSideReady,
  output logic              outSideReady,
  output gfCtrl_t           ctrlQ,
  output gfStrobes_t        stb,
  output logic [BYTE_W-1:0] absorbByte
);

  logic takeIn;
  logic takeOut;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlQ <= '0;
    end else if (ctrlWrEn) begin
      ctrlQ       <= ctrlWrData;
      // CRC may not be enabled together with the generator
      ctrlQ.crcEn <= ctrlWrData.crcEn & ~ctrlWrData.prngEn;
    end
  end

  assign inSideReady  = ctrlQ.crcEn & ~ctrlQ.srcSel;
  assign outSideReady = ctrlQ.crcEn &  ctrlQ.srcSel;
  assign takeIn       = inSideReady  & inSideValid;
  assign takeOut      = outSideReady & outSideValid;
  assign absorbByte   = ctrlQ.srcSel ? outSideData : inSideData;

  always_comb begin
    stb           = '0;
    stb.absorb    = takeIn | takeOut;
    stb.prngByte  = ctrlQ.prngEn & ~ctrlQ.entEn;
    stb.mixBit    = ctrlQ.prngEn &  ctrlQ.entEn;
    stb.rawBit    = ~ctrlQ.prngEn & ctrlQ.entEn;
    stb.loadState = stateWrEn & ~(takeIn | takeOut) & ~ctrlQ.prngEn;
    stb.msbFirst  = ctrlQ.msbFirst;
  end

endmodule

// File: rtl/gf_datapath.sv
module gf_datapath
  import gf_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gfStrobes_t        stb,
  input  logic [BYTE_W-1:0] absorbByte,
  input  logic              polyWrEn,
  input  logic [WIDTH-1:0]  polyWrData,
  input  logic [WIDTH-1:0]  stateWrData,
  input  logic              entropyIn,
  output logic [WIDTH-1:0]  polyRdData,
  output logic [WIDTH-1:0]  stateRdData,
  output logic              rndValid,
  output logic              rndWide,
  output logic [BYTE_W-1:0] rndData
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  function automatic logic [WIDTH-1:0] revBits(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int k = 0; k < WIDTH; k++) r[k] = v[WIDTH-1-k];
    return r;
  endfunction

  // Registers are held in reflected (shift-right) form internally
  logic [WIDTH-1:0]  polyInt;
  logic [WIDTH-1:0]  stateInt;
  logic [WIDTH-1:0]  sWork;
  logic [WIDTH-1:0]  byteNext;
  logic [BYTE_W-1:0] byteBits;
  logic [IDX_W-1:0]  pos;
  logic              fbWork;
  logic              fbOne;
  logic [WIDTH-1:0]  oneNext;

  // Eight unrolled Galois steps; data is zero in generator mode
  always_comb begin
    sWork    = stateInt;
    byteBits = '0;
    pos      = '0;
    fbWork   = 1'b0;
    for (int i = 0; i < BYTE_W; i++) begin
      pos           = stb.msbFirst ? IDX_W'(BYTE_W - 1 - i) : IDX_W'(i);
      fbWork        = sWork[0] ^ (stb.absorb & absorbByte[pos]);
      sWork         = (sWork >> 1) ^ ({WIDTH{fbWork}} & polyInt);
      byteBits[pos] = fbWork;
    end
    byteNext = sWork;
  end

  // Single step with entropy folded into the feedback
  assign fbOne   = stateInt[0] ^ entropyIn;
  assign oneNext = (stateInt >> 1) ^ ({WIDTH{fbOne}} & polyInt);

  assign polyRdData  = stb.msbFirst ? revBits(polyInt)  : polyInt;
  assign stateRdData = stb.msbFirst ? revBits(stateInt) : stateInt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      polyInt <= '0;
    end else if (polyWrEn) begin
      polyInt <= stb.msbFirst ? revBits(polyWrData) : polyWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateInt <= '0;
    end else if (stb.absorb || stb.prngByte) begin
      stateInt <= byteNext;
    end else if (stb.mixBit) begin
      stateInt <= oneNext;
    end else if (stb.loadState) begin
      stateInt <= stb.msbFirst ? revBits(stateWrData) : stateWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rndValid <= 1'b0;
      rndWide  <= 1'b0;
      rndData  <= '0;
    end else begin
      rndValid <= stb.prngByte | stb.mixBit | stb.rawBit;
      rndWide  <= stb.prngByte;
      if (stb.prngByte) begin
        rndData <= byteBits;
      end else begin
        rndData <= {{(BYTE_W-1){1'b0}}, (stb.mixBit ? fbOne : entropyIn)};
      end
    end
  end

endmodule

// File: rtl/gf_engine.sv
module gf_engine
  import gf_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              polyWrEn,
  input  logic [WIDTH-1:0]  polyWrData,
  output logic [WIDTH-1:0]  polyRdData,
  input  logic              stateWrEn,
  input  logic [WIDTH-1:0]  stateWrData,
  output logic [WIDTH-1:0]  stateRdData,
  input  logic              ctrlWrEn,
  input  logic [4:0]        ctrlWrData,
  output logic [4:0]        ctrlRdData,
  input  logic              inSideValid,
  input  logic [BYTE_W-1:0] inSideData,
  output logic              inSideReady,
  input  logic              outSideValid,
  input  logic [BYTE_W-1:0] outSideData,
  output logic              outSideReady,
  input  logic              entropyIn,
  output logic              rndValid,
  output logic              rndWide,
  output logic [BYTE_W-1:0] rndData
);

  gfCtrl_t           ctrlQ;
  gfStrobes_t        stb;
  logic [BYTE_W-1:0] absorbByte;

  gf_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrlWrEn     (ctrlWrEn),
    .ctrlWrData   (gfCtrl_t'(ctrlWrData)),
    .stateWrEn    (stateWrEn),
    .inSideValid  (inSideValid),
    .inSideData   (inSideData),
    .outSideValid (outSideValid),
    .outSideData  (outSideData),
    .inSideReady  (inSideReady),
    .outSideReady (outSideReady),
    .ctrlQ        (ctrlQ),
    .stb          (stb),
    .absorbByte   (absorbByte)
  );

  gf_datapath #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .absorbByte  (absorbByte),
    .polyWrEn    (polyWrEn),
    .polyWrData  (polyWrData),
    .stateWrData (stateWrData),
    .entropyIn   (entropyIn),
    .polyRdData  (polyRdData),
    .stateRdData (stateRdData),
    .rndValid    (rndValid),
    .rndWide     (rndWide),
    .rndData     (rndData)
  );

  assign ctrlRdData = ctrlQ;

endmodule

// File: rtl/gf_engine_chk.sv
module gf_engine_chk #(
  parameter int WIDTH  = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrlWrEn,
  input logic              stateWrEn,
  input logic [4:0]        ctrlRdData,
  input logic [WIDTH-1:0]  stateRdData,
  input logic              inSideReady,
  input logic              outSideReady,
  input logic              rndValid,
  input logic              rndWide,
  input logic [BYTE_W-1:0] rndData
);

  // R6
  crc_prng_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRdData[2] |-> !ctrlRdData[0]);

  // R5
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inSideReady, outSideReady}));

  // R11
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlRdData[2] && !ctrlRdData[3]) |=> !rndValid);

  // R7
  byte_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlRdData[2] && !ctrlRdData[3]) |=> (rndValid && rndWide));

  // R8
  bit_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlRdData[3] |=> (rndValid && !rndWide));

  // R8
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rndValid && !rndWide) |-> (rndData[BYTE_W-1:1] == '0));

  // R9
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlRdData[3] && !ctrlRdData[2] && !ctrlRdData[0] && !ctrlWrEn && !stateWrEn)
      |=> $stable(stateRdData));

endmodule

bind gf_engine gf_engine_chk #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrlWrEn     (ctrlWrEn),
  .stateWrEn    (stateWrEn),
  .ctrlRdData   (ctrlRdData),
  .stateRdData  (stateRdData),
  .inSideReady  (inSideReady),
  .outSideReady (outSideReady),
  .rndValid     (rndValid),
  .rndWide      (rndWide),
  .rndData      (rndData)
);

// File: tb/gf_engine_tb_top.sv
module gf_engine_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        polyWrEn = 1'b0;
  logic [31:0] polyWrData = '0;
  logic [31:0] polyRdData;
  logic        stateWrEn = 1'b0;
  logic [31:0] stateWrData = '0;
  logic [31:0] stateRdData;
  logic        ctrlWrEn = 1'b0;
  logic [4:0]  ctrlWrData = '0;
  logic [4:0]  ctrlRdData;
  logic        inSideValid = 1'b0;
  logic [7:0]  inSideData = '0;
  logic        inSideReady;
  logic        outSideValid = 1'b0;
  logic [7:0]  outSideData = '0;
  logic        outSideReady;
  logic        entropyIn = 1'b0;
  logic        rndValid;
  logic        rndWide;
  logic [7:0]  rndData;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] mPoly;
  logic [31:0] mState;
  logic [8:0]  expQ[$];
  string       tagQ[$];

  always #(CLK_P/2) clk = ~clk;

  gf_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .polyWrEn(polyWrEn), .polyWrData(polyWrData), .polyRdData(polyRdData),
    .stateWrEn(stateWrEn), .stateWrData(stateWrData), .stateRdData(stateRdData),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .inSideValid(inSideValid), .inSideData(inSideData), .inSideReady(inSideReady),
    .outSideValid(outSideValid), .outSideData(outSideData), .outSideReady(outSideReady),
    .entropyIn(entropyIn), .rndValid(rndValid), .rndWide(rndWide), .rndData(rndData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rndValid) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R11 actual=%h expected=none (unexpected output)", {rndWide, rndData});
      end else begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({rndWide, rndData} !== e) begin
          nFails++;
          $display("FAIL %s actual=%h expected=%h", t, {rndWide, rndData}, e);
        end
      end
    end
  end

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = v[31-k];
    return r;
  endfunction

  task automatic wrPoly(input logic [31:0] v);
    @(negedge clk); polyWrEn = 1'b1; polyWrData = v;
    @(negedge clk); polyWrEn = 1'b0;
  endtask

  task automatic wrState(input logic [31:0] v);
    @(negedge clk); stateWrEn = 1'b1; stateWrData = v;
    @(negedge clk); stateWrEn = 1'b0;
  endtask

  task automatic wrCtrl(input logic [4:0] v);
    @(negedge clk); ctrlWrEn = 1'b1; ctrlWrData = v;
    @(negedge clk); ctrlWrEn = 1'b0;
  endtask

  // CRC over "123456789"; msb/useOut from mode; a state write injected at byte wrAt
  task automatic feedCrc(input bit msb, input bit useOut, input int wrAt, input string tag);
    logic [7:0] msg [9];
    for (int i = 0; i < 9; i++) msg[i] = 8'(8'h31 + i);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk("R5 selected ready", {31'b0, useOut ? outSideReady : inSideReady}, 32'd1);
        chk("R5 unselected ready", {31'b0, useOut ? inSideReady : outSideReady}, 32'd0);
      end
      if (useOut) begin
        outSideValid = 1'b1; outSideData = msg[i];
        inSideValid = 1'b1; inSideData = 8'hA5;
      end else begin
        inSideValid = 1'b1; inSideData = msg[i];
        outSideValid = 1'b1; outSideData = 8'h5A;
      end
      stateWrEn = (i == wrAt); stateWrData = 32'h1234_5678;
      for (int b = 0; b < 8; b++) begin
        logic fb;
        if (msb) begin
          fb = mState[31] ^ msg[i][7-b];
          mState = (mState << 1) ^ (fb ? mPoly : 32'h0);
        end else begin
          fb = mState[0] ^ msg[i][b];
          mState = (mState >> 1) ^ (fb ? mPoly : 32'h0);
        end
      end
    end
    @(negedge clk);
    inSideValid = 1'b0; outSideValid = 1'b0; stateWrEn = 1'b0;
    chk(tag, stateRdData, mState);
  endtask

  // Random modes: cv control value, k output cycles, pat entropy pattern
  task automatic runRnd(input logic [4:0] cv, input int k, input logic [15:0] pat);
    bit msb;
    msb = cv[1];
    @(negedge clk); ctrlWrEn = 1'b1; ctrlWrData = cv;
    for (int j = 0; j < k; j++) begin
      logic [7:0] outB;
      logic fb;
      @(negedge clk);
      ctrlWrEn = 1'b0;
      entropyIn = pat[j];
      stateWrEn = cv[2] && (j == 1);
      stateWrData = 32'hDEAD_BEEF;
      if (j == 0 && cv[2]) begin
        chk("R6 crc enable masked", {27'b0, ctrlRdData}, {27'b0, cv & 5'b11110});
        chk("R6 no stream ready", {30'b0, inSideReady, outSideReady}, 32'd0);
      end
      if (cv[2] && !cv[3]) begin
        outB = '0;
        for (int b = 0; b < 8; b++) begin
          if (msb) begin
            fb = mState[31];
            mState = (mState << 1) ^ (fb ? mPoly : 32'h0);
            outB[7-b] = fb;
          end else begin
            fb = mState[0];
            mState = (mState >> 1) ^ (fb ? mPoly : 32'h0);
            outB[b] = fb;
          end
        end
        expQ.push_back({1'b1, outB}); tagQ.push_back("R7");
      end else if (cv[2] && cv[3]) begin
        if (msb) begin
          fb = mState[31] ^ pat[j];
          mState = (mState << 1) ^ (fb ? mPoly : 32'h0);
        end else begin
          fb = mState[0] ^ pat[j];
          mState = (mState >> 1) ^ (fb ? mPoly : 32'h0);
        end
        expQ.push_back({1'b0, 7'b0, fb}); tagQ.push_back("R8");
      end else begin
        expQ.push_back({1'b0, 7'b0, pat[j]}); tagQ.push_back("R9");
      end
      if (j == k - 1) begin
        ctrlWrEn = 1'b1; ctrlWrData = cv & 5'b00010;
      end
    end
    @(negedge clk); ctrlWrEn = 1'b0; stateWrEn = 1'b0;
    @(negedge clk);
    chk("R11 scoreboard drained", expQ.size(), 32'd0);
    chk(cv[2] ? "R10 state after run" : "R9 state unchanged", stateRdData, mState);
  endtask

  initial begin
    #(CLK_P * 150000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 poly", polyRdData, 32'h0);
    chk("R1 state", stateRdData, 32'h0);
    chk("R1 ctrl", {27'b0, ctrlRdData}, 32'h0);
    chk("R1 ready/valid", {29'b0, inSideReady, outSideReady, rndValid}, 32'h0);

    // R2 readback, R3 reflected CRC on input side with R10 injection
    mPoly = 32'hEDB8_8320; mState = 32'hFFFF_FFFF;
    wrPoly(mPoly);
    wrState(mState);
    chk("R2 poly lsb", polyRdData, mPoly);
    chk("R2 state lsb", stateRdData, mState);
    wrCtrl(5'b00001);
    feedCrc(1'b0, 1'b0, 4, "R3 crc lsb (R10 write ignored)");
    chk("R3 known check", stateRdData ^ 32'hFFFF_FFFF, 32'hCBF4_3926);

    // R2 orientation switch, R4 normal CRC via output side (R5)
    wrCtrl(5'b00010);
    chk("R2 poly reversed", polyRdData, 32'h04C1_1DB7);
    chk("R2 state reversed", stateRdData, rev32(mState));
    mPoly = 32'h04C1_1DB7; mState = 32'hFFFF_FFFF;
    wrState(mState);
    chk("R2 state msb", stateRdData, mState);
    wrCtrl(5'b10011);
    feedCrc(1'b1, 1'b1, -1, "R4 crc msb on R5 output side");
    chk("R4 known check", stateRdData, 32'h0376_E6E7);

    // Back to LSB order for generator tests
    wrCtrl(5'b00000);
    mPoly = 32'hEDB8_8320; mState = 32'h0000_0001;
    wrState(mState);
    runRnd(5'b00101, 4, 16'h0);        // R6 with R7
    runRnd(5'b00100, 6, 16'h0);        // R7 lsb
    runRnd(5'b01100, 10, 16'b1011_0010_1100_1011); // R8 lsb
    runRnd(5'b01000, 7, 16'b0000_0000_0110_1001);  // R9

    wrCtrl(5'b00010);
    mPoly = 32'h04C1_1DB7; mState = 32'h8000_0001;
    wrState(mState);
    runRnd(5'b00110, 5, 16'h0);        // R7 msb
    runRnd(5'b01110, 9, 16'b0110_1101_0011_0101); // R8 msb

    // R11 quiet
    wrCtrl(5'b00000);
    repeat (4) begin
      @(negedge clk);
      chk("R11 no output", {31'b0, rndValid}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule